// File: doc/BRIEF.md
# Configurable SPI Master Shift Engine

This block is the serial core of an SPI master. Software-side logic pushes words into a four-entry transmit queue. The engine shifts each word out on MOSI and samples MISO at the same time. Each received word goes into a four-entry receive queue, where the consumer pops it. A one-cycle `tick` input sets the bus rate. Each tick is one half-period of SCLK, so the rate is chosen outside the block.

The configuration inputs set several things:
- word length;
- bit order;
- SCLK idle level;
- the SCLK edges on which data is driven and sampled, chosen independently of each other;
- the length of an idle gap after each word;
- how slave select is handled.

Slave select can follow the engine automatically for a whole burst, or it can be held at a level that software chooses. Configuration must stay unchanged while `busy` is high.

Top module: `spi_shift_master`

## Requirements
- R1: With `busy` low, SCLK sits at `cfg_cpol`. During a word, MOSI changes only on the edge that `cfg_txneg` selects, and MISO is captured on the edge that `cfg_rxneg` selects. For both inputs, 1 means the falling edge and 0 means the rising edge. Only the first bit of a word is already on MOSI before the first edge. The four standard modes map as follows:

  | Mode | `cfg_cpol` | `cfg_rxneg` | `cfg_txneg` |
  |---|---|---|---|
  | 0 | 0 | 0 | 1 |
  | 1 | 0 | 1 | 0 |
  | 2 | 1 | 1 | 0 |
  | 3 | 1 | 0 | 1 |

- R2: Word length is set by `cfg_width`. A value from 8 to 31 gives that many bits, 0 gives 32 bits, and 1 to 7 give 8 bits. A word of N bits produces exactly 2N SCLK edges.
- R3: With `cfg_lsb` = 1, bit 0 of the word goes out first. With `cfg_lsb` = 0, bit N-1 goes out first. The received word is assembled in the same order, so the first bit on the wire lands at the same position it was taken from.
- R4: After the last edge of a word, SCLK stays idle for 2n+1 extra ticks, where n = `cfg_gap`. The last edge of one word and the first edge of the next in the same burst are therefore 2n+2 ticks apart, which is (n+0.5) SCLK periods of idle beyond the normal half period.
- R5: With `cfg_auto_ss` = 1, `ss` is at its active level (`cfg_ss_pol`) whenever `busy` is high, and inactive otherwise. It becomes active one tick before the first edge of a burst. It is released at the end of the gap after the last word, once the transmit queue is empty.
- R6: With `cfg_auto_ss` = 0, `ss` equals `cfg_ss_pol` when `cfg_ss_level` = 1 and the inverse of `cfg_ss_pol` when `cfg_ss_level` = 0.
- R7: `busy` is high from the cycle after a word is taken from the transmit queue until the gap after the last word ends.
- R8: `tx_full` and `tx_empty` report a transmit queue holding 4 and 0 entries. `rx_count` (0 to 4) and `rx_empty` report the receive queue. A push into a full transmit queue is ignored.
- R9: `tx_clear` and `rx_clear` each empty their queue in one cycle. A push or pop in the same cycle is discarded.
- R10: `unit_done` pulses high for one cycle, one cycle after the last edge of each word, and the received word is written to the receive queue at the same moment. A word that arrives while the receive queue is full is dropped, and the queue keeps the older words.
- R11: SCLK changes only in the cycle after a `tick`. The first edge of a word comes one tick after the word is taken from the queue, and each later tick of the word gives one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Half-bit-period enable |
| cfg_width | input | 5 | Word length code |
| cfg_lsb | input | 1 | 1 = least significant bit first |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_txneg | input | 1 | 1 = drive on falling edge |
| cfg_rxneg | input | 1 | 1 = sample on falling edge |
| cfg_gap | input | 4 | Inter-word gap setting n |
| cfg_auto_ss | input | 1 | 1 = engine controls slave select |
| cfg_ss_pol | input | 1 | Active level of slave select |
| cfg_ss_level | input | 1 | Manual select request |
| tx_push | input | 1 | Write `tx_data` into the transmit queue |
| tx_data | input | 32 | Word to send |
| tx_clear | input | 1 | Empty the transmit queue |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_clear | input | 1 | Empty the receive queue |
| rx_data | output | 32 | Head of the receive queue |
| rx_count | output | 3 | Receive queue entries |
| rx_empty | output | 1 | Receive queue empty |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| busy | output | 1 | Transfer in progress |
| unit_done | output | 1 | End-of-word pulse |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss | output | 1 | Slave select |

## Verification
The assertions check every cycle that:
- SCLK rests at its idle level whenever the engine is not busy, and moves only right after a tick;
- slave select tracks its active level in automatic mode;
- the transmit queue is never reported full and empty together, and a clear always leaves it empty;
- `unit_done` never lasts more than one cycle.

Other behaviour can only be seen by running the scenarios with an edge-watching monitor and MISO looped back inverted from MOSI:
- on which edges bits are launched and sampled in each mode;
- that bits leave in the right order for each width;
- the exact gap length between words;
- that a word is dropped when the receive queue overflows.

// File: rtl/spi_shift_master.sv
module spi_shift_master #(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic [4:0]  cfg_width,
  input  logic        cfg_lsb,
  input  logic        cfg_cpol,
  input  logic        cfg_txneg,
  input  logic        cfg_rxneg,
  input  logic [3:0]  cfg_gap,
  input  logic        cfg_auto_ss,
  input  logic        cfg_ss_pol,
  input  logic        cfg_ss_level,
  input  logic        tx_push,
  input  logic [31:0] tx_data,
  input  logic        tx_clear,
  input  logic        rx_pop,
  input  logic        rx_clear,
  output logic [31:0] rx_data,
  output logic [$clog2(DEPTH+1)-1:0] rx_count,
  output logic        rx_empty,
  output logic        tx_empty,
  output logic        tx_full,
  output logic        busy,
  output logic        unit_done,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        ss
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  typedef enum logic [1:0] {IDLE, XFER, GAP} st_t;
  st_t st;

  logic [31:0]   txm [DEPTH];
  logic [31:0]   rxm [DEPTH];
  logic [AW-1:0] twp, trp, rwp, rrp;
  logic [CW-1:0] tcnt;
  logic [31:0]   tsh, rsh, rsh_nxt, rx_word;
  logic [6:0]    half;
  logic [4:0]    gcnt;
  logic          phase;
  logic [5:0]    nbits;

  assign nbits = (cfg_width == 5'd0) ? 6'd32 : (cfg_width < 5'd8) ? 6'd8 : {1'b0, cfg_width};

  wire load     = tick && !tx_empty && (st == IDLE || (st == GAP && gcnt == 5'd0));
  wire edge_now = tick && (st == XFER);
  wire nsclk    = ~phase ^ cfg_cpol;
  wire drv      = edge_now && (nsclk == ~cfg_txneg) && (half != 7'd0);
  wire smp      = edge_now && (nsclk == ~cfg_rxneg);
  wire last     = edge_now && (half == ({nbits, 1'b0} - 7'd1));

  wire tx_wr  = tx_push && !tx_full && !tx_clear;
  wire rx_wr  = last && (rx_count != CW'(DEPTH)) && !rx_clear;
  wire rx_rd  = rx_pop && !rx_empty && !rx_clear;

  assign rsh_nxt = !smp ? rsh : cfg_lsb ? {miso, rsh[31:1]} : {rsh[30:0], miso};
  assign rx_word = cfg_lsb ? (rsh_nxt >> (6'd32 - nbits))
                           : (rsh_nxt & (32'hFFFF_FFFF >> (6'd32 - nbits)));

  assign tx_empty = (tcnt == '0);
  assign tx_full  = (tcnt == CW'(DEPTH));
  assign rx_empty = (rx_count == '0);
  assign rx_data  = rxm[rrp];
  assign busy     = (st != IDLE);
  assign sclk     = phase ^ cfg_cpol;
  assign mosi     = cfg_lsb ? tsh[0] : tsh[nbits[4:0] - 5'd1];
  assign ss       = (cfg_auto_ss ? busy : cfg_ss_level) ? cfg_ss_pol : ~cfg_ss_pol;

  always_ff @(posedge clk) begin
    if (tx_wr) txm[twp] <= tx_data;
    if (rx_wr) rxm[rwp] <= rx_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      twp <= '0; trp <= '0; tcnt <= '0;
    end else if (tx_clear) begin
      twp <= '0; trp <= '0; tcnt <= '0;
    end else begin
      if (tx_wr) twp <= twp + 1'b1;
      if (load)  trp <= trp + 1'b1;
      tcnt <= tcnt + CW'(tx_wr) - CW'(load);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rwp <= '0; rrp <= '0; rx_count <= '0;
    end else if (rx_clear) begin
      rwp <= '0; rrp <= '0; rx_count <= '0;
    end else begin
      if (rx_wr) rwp <= rwp + 1'b1;
      if (rx_rd) rrp <= rrp + 1'b1;
      rx_count <= rx_count + CW'(rx_wr) - CW'(rx_rd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; phase <= 1'b0; half <= '0; gcnt <= '0;
      tsh <= '0; rsh <= '0; unit_done <= 1'b0;
    end else begin
      unit_done <= last;
      if (load) begin
        tsh   <= txm[trp];
        rsh   <= '0;
        half  <= '0;
        phase <= 1'b0;
        st    <= XFER;
      end else begin
        case (st)
          XFER: if (edge_now) begin
            phase <= ~phase;
            half  <= half + 7'd1;
            rsh   <= rsh_nxt;
            if (drv) tsh <= cfg_lsb ? (tsh >> 1) : (tsh << 1);
            if (last) begin
              st   <= GAP;
              gcnt <= {cfg_gap, 1'b0};
            end
          end
          GAP: if (tick) begin
            if (gcnt != 5'd0) gcnt <= gcnt - 5'd1;
            else              st   <= IDLE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_shift_master_chk.sv
module spi_shift_master_chk #(
  parameter int DEPTH = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       cfg_cpol,
  input logic       cfg_auto_ss,
  input logic       cfg_ss_pol,
  input logic       tx_clear,
  input logic [$clog2(DEPTH+1)-1:0] rx_count,
  input logic       tx_empty,
  input logic       tx_full,
  input logic       busy,
  input logic       unit_done,
  input logic       sclk,
  input logic       ss
);
  AST_IDLE_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == cfg_cpol);                                             // R1
  AST_AUTO_SS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_auto_ss && busy) |-> ss == cfg_ss_pol);                             // R5
  AST_TX_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty));                                                 // R8
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= ($clog2(DEPTH+1))'(DEPTH));                                  // R8
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clear |=> tx_empty);                                                  // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done |=> !unit_done);                                               // R10
  AST_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(sclk)) |-> $past(tick));                // R11
endmodule

bind spi_shift_master spi_shift_master_chk #(.DEPTH(DEPTH)) chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_cpol(cfg_cpol),
  .cfg_auto_ss(cfg_auto_ss), .cfg_ss_pol(cfg_ss_pol), .tx_clear(tx_clear),
  .rx_count(rx_count), .tx_empty(tx_empty), .tx_full(tx_full), .busy(busy),
  .unit_done(unit_done), .sclk(sclk), .ss(ss)
);

// File: tb/spi_shift_master_test.sv
`timescale 1ns/1ps
module spi_shift_master_test;
  localparam int TP = 3;

  logic clk = 0, rst_n = 0, tick = 0;
  logic [4:0] cfg_width = 5'd8;
  logic cfg_lsb = 0, cfg_cpol = 0, cfg_txneg = 1, cfg_rxneg = 0;
  logic [3:0] cfg_gap = 0;
  logic cfg_auto_ss = 1, cfg_ss_pol = 0, cfg_ss_level = 0;
  logic tx_push = 0, tx_clear = 0, rx_pop = 0, rx_clear = 0;
  logic [31:0] tx_data = 0;
  logic [31:0] rx_data;
  logic [2:0] rx_count;
  logic rx_empty, tx_empty, tx_full, busy, unit_done, sclk, mosi, ss;
  logic miso;

  assign miso = ~mosi;
  always #2 clk = ~clk;

  spi_shift_master uut (.*);

  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  bit tick_en = 0;
  int ud_cnt = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nb_of(input logic [4:0] w);
    return (w == 0) ? 32 : (w < 8) ? 8 : int'(w);
  endfunction

  function automatic logic ser_bit(input logic [31:0] w, input int i, input int n, input logic lsb);
    return lsb ? w[i] : w[n-1-i];
  endfunction

  function automatic logic [31:0] rx_exp(input logic [31:0] w, input int n);
    return ~w & (32'hFFFF_FFFF >> (32 - n));
  endfunction

  initial begin
    int tc = 0;
    forever @(negedge clk) begin
      tc++;
      tick = tick_en && (tc % TP == 0);
    end
  end

  initial begin
    int edges = 0, bi = 0, cyc = 0, last_cyc = 0;
    bit prev = 0, released = 1, bad = 0, ssbad = 0;
    logic [31:0] cur = 0;
    forever @(negedge clk) begin
      cyc++;
      if (unit_done) ud_cnt++;
      if (!busy) released = 1;
      if (busy && sclk !== prev) begin
        if (edges == 0) begin
          cur = (exp_q.size() > 0) ? exp_q.pop_front() : 32'h0;
          bi = 0; bad = 0; ssbad = 0;
          if (!released)
            check(cyc - last_cyc == (2*cfg_gap + 2)*TP, "R4 gap", cyc - last_cyc, (2*cfg_gap + 2)*TP);
          else
            check(sclk == ~cfg_cpol, "R1 first edge leaves idle", sclk, ~cfg_cpol);
        end
        if (ss !== cfg_ss_pol) ssbad = 1;
        if (sclk == !cfg_rxneg) begin
          if (mosi !== ser_bit(cur, bi, nb_of(cfg_width), cfg_lsb)) bad = 1;
          bi++;
        end
        edges++;
        if (edges == 2*nb_of(cfg_width)) begin
          check(!bad && bi == nb_of(cfg_width), "R3/R1/R2 serial bits", bad, 0);
          check(!ssbad, "R5 ss active on edges", ssbad, 0);
          last_cyc = cyc; released = 0; edges = 0;
        end
      end
      prev = sclk;
    end
  end

  task automatic set_cfg(input int mode, input logic [4:0] w, input logic lsb, input logic [3:0] g);
    @(negedge clk);
    cfg_cpol  = (mode >= 2);
    cfg_txneg = (mode == 0 || mode == 3);
    cfg_rxneg = (mode == 1 || mode == 2);
    cfg_width = w; cfg_lsb = lsb; cfg_gap = g;
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    if (!tx_full) exp_q.push_back(w);
    tx_push = 1; tx_data = w;
    @(negedge clk);
    tx_push = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy || !tx_empty);
  endtask

  task automatic burst(input int k);
    logic [31:0] arr [4];
    int n = nb_of(cfg_width);
    ud_cnt = 0;
    for (int j = 0; j < k; j++) begin
      arr[j] = $urandom;
      push(arr[j]);
    end
    repeat (2*TP) @(negedge clk);
    check(busy == 1, "R7 busy during transfer", busy, 1);
    wait_idle();
    @(negedge clk);
    check(sclk == cfg_cpol, "R1 idle level", sclk, cfg_cpol);
    check(rx_count == k, "R10 rx count", rx_count, k);
    check(ud_cnt == k, "R10 unit_done count", ud_cnt, k);
    for (int j = 0; j < k; j++) begin
      @(negedge clk);
      check(rx_data == rx_exp(arr[j], n), "R10/R2 rx word", rx_data, rx_exp(arr[j], n));
      rx_pop = 1;
      @(negedge clk);
      rx_pop = 0;
    end
  endtask

  initial begin
    logic [31:0] ov [5];
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check(busy == 0 && tx_empty && rx_empty && rx_count == 0, "R7/R8 reset state", busy, 0);
    check(ss == 1 && sclk == 0 && unit_done == 0, "R5/R1 reset pins", {ss, sclk}, 2'b10);
    rst_n = 1;

    for (int j = 0; j < 5; j++) push(32'hA0 + j);
    check(tx_full == 1 && tx_empty == 0, "R8 full after four", tx_full, 1);
    check(exp_q.size() == 4, "R8 fifth push ignored", exp_q.size(), 4);
    @(negedge clk); tx_clear = 1; @(negedge clk); tx_clear = 0;
    exp_q.delete();
    check(tx_empty == 1 && tx_full == 0, "R9 tx clear", tx_empty, 1);
    repeat (10) @(negedge clk);
    check(busy == 0, "R11 no transfer without tick", busy, 0);

    cfg_auto_ss = 0; cfg_ss_level = 1; cfg_ss_pol = 0; @(negedge clk);
    check(ss == 0, "R6 manual active low", ss, 0);
    cfg_ss_pol = 1; @(negedge clk);
    check(ss == 1, "R6 manual active high", ss, 1);
    cfg_ss_level = 0; @(negedge clk);
    check(ss == 0, "R6 manual released", ss, 0);
    cfg_auto_ss = 1; cfg_ss_pol = 0;

    tick_en = 1;
    set_cfg(0, 5'd8, 0, 4'd0);  burst(4);
    set_cfg(1, 5'd0, 1, 4'd2);  burst(3);
    set_cfg(2, 5'd13, 0, 4'd15); burst(2);
    set_cfg(3, 5'd5, 1, 4'd1);  burst(4);
    set_cfg(0, 5'd31, 1, 4'd3); burst(1);
    for (int i = 0; i < 10; i++) begin
      set_cfg($urandom % 4, 5'($urandom), 1'($urandom), 4'($urandom));
      cfg_ss_pol = 1'($urandom);
      burst(1 + $urandom % 4);
    end

    cfg_ss_pol = 0;
    set_cfg(1, 5'd8, 0, 4'd0);
    for (int j = 0; j < 4; j++) begin ov[j] = $urandom; push(ov[j]); end
    do @(negedge clk); while (tx_full);
    ov[4] = $urandom; push(ov[4]);
    wait_idle();
    @(negedge clk);
    check(rx_count == 4, "R10 overflow keeps four", rx_count, 4);
    for (int j = 0; j < 4; j++) begin
      check(rx_data == rx_exp(ov[j], 8), "R10 older words kept", rx_data, rx_exp(ov[j], 8));
      rx_pop = 1; @(negedge clk); rx_pop = 0; @(negedge clk);
    end
    push(32'h5A); wait_idle(); @(negedge clk);
    check(rx_empty == 0, "R9 rx filled before clear", rx_empty, 0);
    rx_clear = 1; @(negedge clk); rx_clear = 0; @(negedge clk);
    check(rx_empty == 1 && rx_count == 0, "R9 rx clear", rx_count, 0);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule